// File: doc/BRIEF.md
# Systolic 8-bit Matrix Multiply Array

This block is a square grid of N by N multiply-accumulate cells. It forms one matrix-vector product on every clock. The grid holds its weights in place. Before any computation, a load phase shifts the weight matrix into the grid, one row of N bytes per beat, and a one-cycle pulse marks the end of each full load. Once the weights are in, the block can take one activation vector of N bytes per clock.

Each byte of an activation vector enters its own grid row. Row r is delayed by r cycles on entry, so that the values meet the partial sums at the right cell. Each byte then moves one cell to the right per clock. The partial sums move one cell down per clock. Each cell adds the product of its weight and the passing activation to the partial sum it receives from above.

The sums at the bottom edge are re-aligned, so that all N results of one vector leave together on a single cycle. A fresh vector can enter on every clock. This gives one full result vector per clock, and no operand is read more than once.

A mode bit is sampled with every vector. It selects whether the weights and activations are read as signed or unsigned bytes. The mode bit travels through the grid together with its vector, so vectors with different modes may follow each other with no gap.

Top module: `mxu_systolic`

## Requirements
- R1: While reset is asserted and on the first cycle after reset is released, `res_valid_o`, `wload_done_o` and `res_vec_o` are all zero.
- R2: Each cycle with `wload_valid_i` high shifts the grid's weights down by one row and writes `wload_row_i` into row 0. Byte c, at bits [8c+7:8c], goes to column c. After N consecutive beats, the row given on beat k sits in grid row N-1-k. While `wload_valid_i` is low, the weights are held, whatever `wload_row_i` carries. A later load fully replaces the earlier weights.
- R3: `wload_done_o` is high for exactly one cycle, on the cycle after every Nth load beat counted since reset. It is low at all other times.
- R4: For a valid input vector x, with byte r at bits [8r+7:8r], output element c at bits [32c+31:32c] equals the sum over r of W[r][c]·x[r]. Here W[r][c] is the weight in grid row r, column c, and the sum is a two's-complement value.
- R5: When `mode_i` = 1, both the weights and the activations are read as signed bytes (-128..127). When `mode_i` = 0, both are read as unsigned bytes (0..255).
- R6: `mode_i` is sampled together with each valid vector. It governs only that vector's result, so back-to-back vectors with alternating modes are each computed correctly.
- R7: The result of a vector sampled on a given rising edge appears, with `res_valid_o` high, on the 2N-1th rising edge after that edge. Results leave in input order, one per clock for back-to-back inputs, and the gaps in the input stream are kept.
- R8: While `res_valid_o` is low, `res_vec_o` holds the last valid result, whatever data is presented on idle inputs.
- R9: The sums are exact at the operand extremes: all -128 with all -128 (signed), all 255 with all 255 (unsigned), and mixed extremes. The 32-bit sums do not overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 1 = signed operands, 0 = unsigned; sampled with each vector |
| wload_valid_i | input | 1 | Weight load beat |
| wload_row_i | input | N*8 | One weight row, column c at bits [8c+7:8c] |
| wload_done_o | output | 1 | One-cycle pulse after every Nth load beat |
| in_valid_i | input | 1 | Activation vector valid |
| in_vec_i | input | N*8 | Activation vector, row r at bits [8r+7:8r] |
| res_valid_o | output | 1 | Result vector valid |
| res_vec_o | output | N*32 | Result vector, column c at bits [32c+31:32c] |

## Verification
The bench drives long back-to-back streams in which the mode alternates on every vector. A design that reads the mode globally, instead of carrying it with each vector, would extend some rows with the wrong sign. It also loads all-0x80 and all-0xFF weight matrices against extreme activations. A narrow accumulator or a misplaced sign extension would give a wrong sum on exactly these cases.

Every result is checked against the cycle on which it is expected, including streams with random gaps. This exposes any error in the skew or deskew depth, or a valid pipeline that is one stage off. Idle cycles carry random data on both input buses, so a design that updates its output or its weights without a valid flag changes a value that the bench then reads.

A reload with a fresh matrix checks the row order of the shift-in.

// File: rtl/sa_pkg.sv
package sa_pkg;
  typedef enum logic {
    MODE_UNSIGNED = 1'b0,
    MODE_SIGNED   = 1'b1
  } mode_e;
endpackage

// File: rtl/sa_delay.sv
// Fixed-depth register delay line, D >= 1.
module sa_delay #(
  parameter int W = 8,
  parameter int D = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [D];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < D; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < D; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[D-1];
endmodule

// File: rtl/sa_mac_cell.sv
// Weight-stationary MAC cell: activation moves right, partial sum moves down.
module sa_mac_cell #(
  parameter int DATA_W = 8,
  parameter int ACC_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wload_i,
  input  logic [DATA_W-1:0] w_i,
  output logic [DATA_W-1:0] w_o,
  input  logic [DATA_W:0]   act_i,
  input  logic              sgn_i,
  output logic [DATA_W:0]   act_o,
  output logic              sgn_o,
  input  logic [ACC_W-1:0]  psum_i,
  output logic [ACC_W-1:0]  psum_o
);
  localparam int PROD_W = 2 * DATA_W + 2;

  logic [DATA_W-1:0]        w_q;
  logic [DATA_W:0]          act_q;
  logic                     sgn_q;
  logic [ACC_W-1:0]         psum_q;
  logic signed [DATA_W:0]   a_s;
  logic signed [DATA_W:0]   w_s;
  logic signed [PROD_W-1:0] prod;
  logic [ACC_W-1:0]         prod_ext;

  // weight extended with the mode bit that travels with this vector
  always_comb begin
    a_s      = act_i;
    w_s      = {sgn_i & w_q[DATA_W-1], w_q};
    prod     = PROD_W'(a_s) * PROD_W'(w_s);
    prod_ext = {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      w_q    <= '0;
      act_q  <= '0;
      sgn_q  <= 1'b0;
      psum_q <= '0;
    end else begin
      if (wload_i) w_q <= w_i;
      act_q  <= act_i;
      sgn_q  <= sgn_i;
      psum_q <= psum_i + prod_ext;
    end
  end

  assign w_o    = w_q;
  assign act_o  = act_q;
  assign sgn_o  = sgn_q;
  assign psum_o = psum_q;
endmodule

// File: rtl/sa_wload_ctrl.sv
// Counts load beats; pulses done after every N-th.
module sa_wload_ctrl #(
  parameter int N = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wload_valid_i,
  output logic done_o
);
  localparam int               CNT_W = (N > 1) ? $clog2(N) : 1;
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(N - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= wload_valid_i && (cnt_q == LAST);
      if (wload_valid_i) begin
        if (cnt_q == LAST) cnt_q <= '0;
        else               cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign done_o = done_q;
endmodule

// File: rtl/mxu_systolic.sv
module mxu_systolic
  import sa_pkg::*;
#(
  parameter int N      = 4,
  parameter int DATA_W = 8,
  parameter int ACC_W  = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                mode_i,
  input  logic                wload_valid_i,
  input  logic [N*DATA_W-1:0] wload_row_i,
  output logic                wload_done_o,
  input  logic                in_valid_i,
  input  logic [N*DATA_W-1:0] in_vec_i,
  output logic                res_valid_o,
  output logic [N*ACC_W-1:0]  res_vec_o
);
  localparam int AW   = DATA_W + 1;
  localparam int VLAT = 2 * N - 1;

  logic [AW-1:0]     act_w  [N][N+1];
  logic              sgn_w  [N][N+1];
  logic [ACC_W-1:0]  psum_w [N+1][N];
  logic [DATA_W-1:0] wt_w   [N+1][N];
  logic [ACC_W-1:0]  col_al [N];
  logic              vec_sgn;
  logic              v_al;
  logic              res_valid_q;
  logic [N*ACC_W-1:0] res_q;

  assign vec_sgn = (mode_i == MODE_SIGNED);

  // input skew: row r enters r cycles late, carrying its mode bit
  for (genvar r = 0; r < N; r++) begin : g_skew
    logic [DATA_W-1:0] x;
    logic [AW:0]       ent;
    assign x   = in_vec_i[r*DATA_W +: DATA_W];
    assign ent = {vec_sgn, vec_sgn & x[DATA_W-1], x};
    if (r == 0) begin : g_direct
      assign {sgn_w[r][0], act_w[r][0]} = ent;
    end else begin : g_dly
      logic [AW:0] dq;
      sa_delay #(.W(AW + 1), .D(r)) u_dly (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   (ent),
        .q_o   (dq)
      );
      assign {sgn_w[r][0], act_w[r][0]} = dq;
    end
  end

  for (genvar c = 0; c < N; c++) begin : g_top
    assign psum_w[0][c] = '0;
    assign wt_w[0][c]   = wload_row_i[c*DATA_W +: DATA_W];
  end

  for (genvar r = 0; r < N; r++) begin : g_row
    for (genvar c = 0; c < N; c++) begin : g_col
      sa_mac_cell #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_cell (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .wload_i(wload_valid_i),
        .w_i    (wt_w[r][c]),
        .w_o    (wt_w[r+1][c]),
        .act_i  (act_w[r][c]),
        .sgn_i  (sgn_w[r][c]),
        .act_o  (act_w[r][c+1]),
        .sgn_o  (sgn_w[r][c+1]),
        .psum_i (psum_w[r][c]),
        .psum_o (psum_w[r+1][c])
      );
    end
  end

  // output deskew: column c waits N-1-c cycles
  for (genvar c = 0; c < N; c++) begin : g_deskew
    if (c == N - 1) begin : g_direct
      assign col_al[c] = psum_w[N][c];
    end else begin : g_dly
      sa_delay #(.W(ACC_W), .D(N - 1 - c)) u_dly (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   (psum_w[N][c]),
        .q_o   (col_al[c])
      );
    end
  end

  sa_delay #(.W(1), .D(VLAT)) u_vdly (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (in_valid_i),
    .q_o   (v_al)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_q <= 1'b0;
      res_q       <= '0;
    end else begin
      res_valid_q <= v_al;
      if (v_al) begin
        for (int c = 0; c < N; c++) res_q[c*ACC_W +: ACC_W] <= col_al[c];
      end
    end
  end

  sa_wload_ctrl #(.N(N)) u_wctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wload_valid_i(wload_valid_i),
    .done_o       (wload_done_o)
  );

  assign res_valid_o = res_valid_q;
  assign res_vec_o   = res_q;
endmodule

// File: rtl/mxu_systolic_chk.sv
module mxu_systolic_chk #(
  parameter int N     = 4,
  parameter int ACC_W = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wload_valid_i,
  input logic               wload_done_o,
  input logic               in_valid_i,
  input logic               res_valid_o,
  input logic [N*ACC_W-1:0] res_vec_o
);
  // independent model of result timing: 2N register stages
  logic [2*N-1:0] vsh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vsh_q <= '0;
    else         vsh_q <= {vsh_q[2*N-2:0], in_valid_i};
  end

  AST_VALID_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o == vsh_q[2*N-1]); // R7

  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wload_done_o |=> !wload_done_o); // R3

  AST_DONE_AFTER_BEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wload_done_o |-> $past(wload_valid_i)); // R3

  AST_RES_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_valid_o |-> $stable(res_vec_o)); // R8
endmodule

bind mxu_systolic mxu_systolic_chk #(.N(N), .ACC_W(ACC_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wload_valid_i(wload_valid_i),
  .wload_done_o (wload_done_o),
  .in_valid_i   (in_valid_i),
  .res_valid_o  (res_valid_o),
  .res_vec_o    (res_vec_o)
);

// File: tb/sim_mxu_systolic.sv
module sim_mxu_systolic;
  localparam int N          = 4;
  localparam int VW         = N * 32;
  localparam int XW         = N * 8;
  localparam int CLK_PERIOD = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode = 1'b0;
  logic          wload_valid = 1'b0;
  logic [XW-1:0] wload_row = '0;
  logic          wload_done;
  logic          in_valid = 1'b0;
  logic [XW-1:0] in_vec = '0;
  logic          res_valid;
  logic [VW-1:0] res_vec;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  int wr = 0;
  int rd = 0;
  int done_cnt = 0;
  int done_last = 0;
  bit finished = 1'b0;

  logic [7:0]    wmat    [N][N];
  logic [VW-1:0] exp_vec [512];
  int            exp_cyc [512];
  string         exp_tag [512];

  mxu_systolic #(.N(N), .DATA_W(8), .ACC_W(32)) u0 (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .mode_i       (mode),
    .wload_valid_i(wload_valid),
    .wload_row_i  (wload_row),
    .wload_done_o (wload_done),
    .in_valid_i   (in_valid),
    .in_vec_i     (in_vec),
    .res_valid_o  (res_valid),
    .res_vec_o    (res_vec)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [VW-1:0] act, input logic [VW-1:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  function automatic int opv(input logic [7:0] v, input logic s);
    return s ? int'($signed(v)) : int'(v);
  endfunction

  function automatic logic [VW-1:0] ref_mv(input logic [XW-1:0] x, input logic s);
    logic [VW-1:0] res;
    for (int c = 0; c < N; c++) begin
      int acc = 0;
      for (int r = 0; r < N; r++) acc += opv(wmat[r][c], s) * opv(x[r*8 +: 8], s);
      res[c*32 +: 32] = acc;
    end
    return res;
  endfunction

  function automatic logic [XW-1:0] rnd_vec();
    logic [XW-1:0] v;
    for (int i = 0; i < N; i++) v[i*8 +: 8] = 8'($urandom);
    return v;
  endfunction

  function automatic logic [XW-1:0] fill_vec(input logic [7:0] b);
    return {N{b}};
  endfunction

  // result and done monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (wload_done) begin
        done_cnt++;
        done_last = cyc;
      end
      if (res_valid) begin
        if (rd >= wr) begin
          check(1'b0, "R7", "unexpected result", res_vec, '0);
        end else begin
          check(res_vec == exp_vec[rd], exp_tag[rd], "result vector", res_vec, exp_vec[rd]);
          check(cyc == exp_cyc[rd], "R7", "result cycle", VW'(cyc), VW'(exp_cyc[rd]));
          rd++;
        end
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) begin
      @(posedge clk); #1;
      in_valid    = 1'b0;
      in_vec      = rnd_vec();
      mode        = 1'($urandom);
      wload_valid = 1'b0;
      wload_row   = rnd_vec();
    end
  endtask

  task automatic send_vec(input logic [XW-1:0] x, input logic s, input string tag);
    @(posedge clk); #1;
    in_valid     = 1'b1;
    in_vec       = x;
    mode         = s;
    exp_vec[wr]  = ref_mv(x, s);
    exp_cyc[wr]  = cyc + 2 * N;
    exp_tag[wr]  = tag;
    wr++;
  endtask

  task automatic drain();
    idle(1);
    while (rd != wr) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic load_weights();
    int k0 = 0;
    int d0 = done_cnt;
    for (int k = 0; k < N; k++) begin
      @(posedge clk); #1;
      if (k == 0) k0 = cyc;
      wload_valid = 1'b1;
      for (int c = 0; c < N; c++) wload_row[c*8 +: 8] = wmat[N-1-k][c];
    end
    idle(1);
    repeat (2) @(negedge clk);
    check(done_cnt == d0 + 1, "R3", "done pulse count", VW'(done_cnt - d0), VW'(1));
    check(done_last == k0 + N, "R3", "done pulse cycle", VW'(done_last), VW'(k0 + N));
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check(res_valid == 1'b0, "R1", "valid in reset", VW'(res_valid), '0);
    check(wload_done == 1'b0, "R1", "done in reset", VW'(wload_done), '0);
    check(res_vec == '0, "R1", "result in reset", res_vec, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check(res_valid == 1'b0 && wload_done == 1'b0 && res_vec == '0, "R1",
          "outputs after release", res_vec, '0);
  endtask

  task automatic t_random_weights();
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) wmat[r][c] = 8'($urandom);
    load_weights();
  endtask

  task automatic t_unsigned();
    for (int i = 0; i < 12; i++) send_vec(rnd_vec(), 1'b0, "R4");
    drain();
  endtask

  task automatic t_signed();
    for (int i = 0; i < 12; i++) send_vec(rnd_vec(), 1'b1, "R5");
    drain();
  endtask

  task automatic t_mixed_mode();
    for (int i = 0; i < 12; i++) send_vec(rnd_vec(), 1'(i % 2), "R6");
    drain();
  endtask

  task automatic t_gaps();
    for (int i = 0; i < 8; i++) begin
      send_vec(rnd_vec(), 1'($urandom), "R7");
      idle(int'($urandom % 4));
    end
    drain();
  endtask

  task automatic t_hold();
    logic [VW-1:0] snap;
    snap = res_vec;
    check(snap == exp_vec[wr-1], "R8", "held last result", snap, exp_vec[wr-1]);
    for (int i = 0; i < 6; i++) begin
      idle(1);
      @(negedge clk);
      check(res_valid == 1'b0, "R8", "valid while idle", VW'(res_valid), '0);
      check(res_vec == snap, "R8", "result held while idle", res_vec, snap);
    end
  endtask

  task automatic t_extremes();
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) wmat[r][c] = 8'h80;
    load_weights();
    send_vec(fill_vec(8'h80), 1'b1, "R9");
    send_vec(fill_vec(8'h7f), 1'b1, "R9");
    send_vec(fill_vec(8'hff), 1'b0, "R9");
    send_vec(fill_vec(8'h80), 1'b0, "R9");
    drain();
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) wmat[r][c] = 8'hff;
    load_weights();
    send_vec(fill_vec(8'hff), 1'b0, "R9");
    send_vec(fill_vec(8'hff), 1'b1, "R9");
    send_vec(fill_vec(8'h80), 1'b1, "R9");
    send_vec(fill_vec(8'h00), 1'b0, "R9");
    drain();
  endtask

  task automatic t_reload();
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) wmat[r][c] = 8'($urandom);
    load_weights();
    idle(5);
    for (int i = 0; i < 8; i++) send_vec(rnd_vec(), 1'($urandom), "R2");
    drain();
  endtask

  initial begin
    t_reset();
    t_random_weights();
    t_unsigned();
    t_signed();
    t_mixed_mode();
    t_gaps();
    t_hold();
    t_extremes();
    t_reload();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule